// File: doc/BRIEF.md
# Double-Rate Line Read Sequencer

This block sequences a line store that is filled at one rate and emptied at twice that rate. It produces the write address and write line strobe for a line of 5,048 bytes, counting written lines, and on the read side it produces two complete read passes of the same line. The read clock runs at exactly twice the write clock, and both clocks share rising edges. The storage array sits outside the block and is addressed by the two address outputs.

The first read pass starts halfway through writing a line. Because reads run at double speed, that pass finishes at the same moment the write of the line finishes. Near its end the first pass catches up with the write that is still in progress, so the block raises an undefined flag on those final outputs. The number of flagged outputs is 21 for the fast timing grade and 15 for the slow grade. The second pass runs during the first half of the next write line. It reads the finished line before the new write overwrites any of its addresses, so every byte it returns is valid.

In steady state the passes follow each other with no gap. Each write line carries one write strobe and two read strobes.

Top module: `line_rate_doubler`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are: write address 0, write strobe 1, write line index 0, read valid 0, read strobe 0, read undefined 0, pass 0.
- R2: The write address increases by one on every write clock edge and wraps from 5,047 to 0. The write strobe is high in exactly the cycle whose write address is 0. The write line index increases by one (modulo 256) at each wrap.
- R3: A first read pass begins on the first read clock edge after the write address reaches 2,524 (half the line). In that cycle: read strobe high, read address 0, pass output 0 (first pass), read valid high, and the read line index equal to the current write line index.
- R4: Within a pass, the read address increases by one on every read clock edge up to 5,047, and the pass value does not change.
- R5: On the read edge after the first pass shows address 5,047, the second pass begins: read strobe high, read address 0, pass output 1, read line index unchanged.
- R6: The undefined flag is high only during the first pass (pass 0), at read addresses from 5,048 − n through 5,047. It is low for the whole second pass and whenever read valid is low.
- R7: n is 21 when the grade select input is 0 and 15 when it is 1. Each complete first pass flags exactly n outputs.
- R8: Once reading has started, the read edge after the second pass shows address 5,047 begins the next line's first pass, so read valid never drops.
- R9: Every output that is not flagged is read after its byte for the current read line has been written, and before the next line overwrites that address. This holds for all 5,048 bytes of the second pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock, twice the write frequency, edge aligned |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| slowGrade | input | 1 | 0: fast grade (21 flagged), 1: slow grade (15 flagged) |
| wrAddr | output | 13 | Write address for the line store |
| wrRst | output | 1 | Write line strobe, high in the address-0 cycle |
| wrLine | output | 8 | Index of the line being written |
| rdAddr | output | 13 | Read address for the line store |
| rdRst | output | 1 | Read pass strobe, high in the address-0 cycle of each pass |
| rdPass | output | 1 | 0 during the first pass, 1 during the second |
| rdValid | output | 1 | A read pass is in progress |
| rdUndef | output | 1 | The current read output may be corrupted |
| rdLine | output | 8 | Index of the line being read |

## Verification
The end of a line's second read pass and the detection of the next line's mid-write marker fall on the same read edge in every steady-state line. The sequencer must start a new first pass at that edge, not idle and not wrap the second pass. This is provoked by running the block continuously across several lines in both timing grades. It is judged at the ports: the sample that shows pass 0, address 0 and a read strobe must directly follow a sample at pass 1, address 5,047, and must see the write address at the half-line point. Each unflagged read is also checked against a write count kept independently in the bench, to confirm that the byte is current.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_FIRST  = 2'd1,
    RD_SECOND = 2'd2
  } rdPhase_e;

  // Strobes from the sequencer to the address datapath.
  typedef struct packed {
    logic wrClr;
    logic rdClr;
    logic rdInc;
  } addrCmd_t;

endpackage

// File: rtl/lrc_addr_path.sv
module lrc_addr_path
  import lrc_pkg::*;
#(
  parameter int LINE_LEN   = 5048,
  parameter int UNDEF_FAST = 21,
  parameter int UNDEF_SLOW = 15,
  parameter int ADDR_W     = $clog2(LINE_LEN)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              slowGrade,
  input  addrCmd_t          cmd,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrAtLast,
  output logic              wrAtHalfNext,
  output logic              rdAtLast,
  output logic              rdInTail
);

  localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] HALF_PREV = ADDR_W'(LINE_LEN / 2 - 1);
  localparam logic [ADDR_W-1:0] TAIL_FAST = ADDR_W'(LINE_LEN - UNDEF_FAST);
  localparam logic [ADDR_W-1:0] TAIL_SLOW = ADDR_W'(LINE_LEN - UNDEF_SLOW);

  logic [ADDR_W-1:0] tailStart;

  // Write address: runs freely and wraps at the end of the line.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)          wrAddr <= '0;
    else if (cmd.wrClr) wrAddr <= '0;
    else                wrAddr <= wrAddr + 1'b1;
  end

  // Read address: cleared at each pass start, holds when idle.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdAddr <= '0;
    else if (cmd.rdClr) rdAddr <= '0;
    else if (cmd.rdInc) rdAddr <= rdAddr + 1'b1;
  end

  always_comb begin
    tailStart    = slowGrade ? TAIL_SLOW : TAIL_FAST;
    wrAtLast     = (wrAddr == LAST_IDX);
    wrAtHalfNext = (wrAddr == HALF_PREV);
    rdAtLast     = (rdAddr == LAST_IDX);
    rdInTail     = (rdAddr >= tailStart);
  end

  // R2
  wr_wrap_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrAddr == LAST_IDX) |=> (wrAddr == '0));

  // R4
  rd_range_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdAddr <= LAST_IDX));

endmodule

// File: rtl/lrc_seq_ctrl.sv
module lrc_seq_ctrl
  import lrc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int LINE_ID_W = 8
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rstN,
  input  logic                 wrAtLast,
  input  logic                 wrAtHalfNext,
  input  logic                 rdAtLast,
  input  logic                 rdInTail,
  input  logic [ADDR_W-1:0]    rdAddr,
  output addrCmd_t             cmd,
  output logic                 wrRst,
  output logic [LINE_ID_W-1:0] wrLine,
  output logic                 rdRst,
  output logic                 rdPass,
  output logic                 rdValid,
  output logic                 rdUndef,
  output logic [LINE_ID_W-1:0] rdLine
);

  rdPhase_e phase, phaseNext;
  logic midTgl, midSeen, newLine;
  logic startFirst, startSecond, finishPass;

  // ---------------- write side ----------------
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrRst  <= 1'b1;
      wrLine <= '0;
      midTgl <= 1'b0;
    end else begin
      wrRst <= wrAtLast;
      if (wrAtLast)     wrLine <= wrLine + 1'b1;
      if (wrAtHalfNext) midTgl <= ~midTgl;
    end
  end

  // ---------------- read side ----------------
  // The marker toggle is stable for a whole write cycle, and the read clock
  // is edge aligned with the write clock, so it can be sampled directly.
  always_comb begin
    newLine     = midTgl ^ midSeen;
    startFirst  = newLine;
    startSecond = !newLine && (phase == RD_FIRST) && rdAtLast;
    finishPass  = !newLine && (phase == RD_SECOND) && rdAtLast;
    phaseNext   = phase;
    if (startFirst)       phaseNext = RD_FIRST;
    else if (startSecond) phaseNext = RD_SECOND;
    else if (finishPass)  phaseNext = RD_IDLE;
    cmd.wrClr = wrAtLast;
    cmd.rdClr = startFirst || startSecond;
    cmd.rdInc = (phase != RD_IDLE) && !rdAtLast;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      phase   <= RD_IDLE;
      midSeen <= 1'b0;
      rdRst   <= 1'b0;
      rdLine  <= '0;
    end else begin
      phase   <= phaseNext;
      midSeen <= midTgl;
      rdRst   <= startFirst || startSecond;
      if (startFirst) rdLine <= wrLine;
    end
  end

  always_comb begin
    rdPass  = (phase == RD_SECOND);
    rdValid = (phase != RD_IDLE);
    rdUndef = (phase == RD_FIRST) && rdInTail;
  end

  // R3
  first_start_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (phase == RD_IDLE && newLine) |=> (rdRst && rdValid && !rdPass && rdAddr == '0));

  // R5
  pass_chain_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (phase == RD_FIRST && rdAtLast && !newLine) |=> (rdRst && rdPass && rdAddr == '0));

  // R8
  line_chain_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (phase == RD_SECOND && rdAtLast && newLine) |=> (rdRst && rdValid && !rdPass));

endmodule

// File: rtl/line_rate_doubler.sv
module line_rate_doubler
  import lrc_pkg::*;
#(
  parameter int LINE_LEN   = 5048,
  parameter int UNDEF_FAST = 21,
  parameter int UNDEF_SLOW = 15,
  parameter int LINE_ID_W  = 8
) (
  input  logic                          wrClk,
  input  logic                          rdClk,
  input  logic                          rstN,
  input  logic                          slowGrade,
  output logic [$clog2(LINE_LEN)-1:0]   wrAddr,
  output logic                          wrRst,
  output logic [LINE_ID_W-1:0]          wrLine,
  output logic [$clog2(LINE_LEN)-1:0]   rdAddr,
  output logic                          rdRst,
  output logic                          rdPass,
  output logic                          rdValid,
  output logic                          rdUndef,
  output logic [LINE_ID_W-1:0]          rdLine
);

  localparam int ADDR_W = $clog2(LINE_LEN);
  localparam logic [ADDR_W-1:0] TAIL_FAST = ADDR_W'(LINE_LEN - UNDEF_FAST);
  localparam logic [ADDR_W-1:0] TAIL_SLOW = ADDR_W'(LINE_LEN - UNDEF_SLOW);

  addrCmd_t cmd;
  logic wrAtLast, wrAtHalfNext, rdAtLast, rdInTail;

  lrc_addr_path #(
    .LINE_LEN  (LINE_LEN),
    .UNDEF_FAST(UNDEF_FAST),
    .UNDEF_SLOW(UNDEF_SLOW),
    .ADDR_W    (ADDR_W)
  ) path_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .slowGrade   (slowGrade),
    .cmd         (cmd),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .wrAtLast    (wrAtLast),
    .wrAtHalfNext(wrAtHalfNext),
    .rdAtLast    (rdAtLast),
    .rdInTail    (rdInTail)
  );

  lrc_seq_ctrl #(
    .ADDR_W   (ADDR_W),
    .LINE_ID_W(LINE_ID_W)
  ) ctrl_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrAtLast    (wrAtLast),
    .wrAtHalfNext(wrAtHalfNext),
    .rdAtLast    (rdAtLast),
    .rdInTail    (rdInTail),
    .rdAddr      (rdAddr),
    .cmd         (cmd),
    .wrRst       (wrRst),
    .wrLine      (wrLine),
    .rdRst       (rdRst),
    .rdPass      (rdPass),
    .rdValid     (rdValid),
    .rdUndef     (rdUndef),
    .rdLine      (rdLine)
  );

  // R2
  wr_strobe_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    wrRst |-> (wrAddr == '0));

  // R3
  rd_strobe_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    rdRst |-> (rdAddr == '0 && rdValid));

  // R6
  undef_onset_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(rdUndef) |-> (!rdPass && rdAddr == (slowGrade ? TAIL_SLOW : TAIL_FAST)));

  // R6
  undef_pass_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    rdPass |-> !rdUndef);

endmodule

// File: tb/line_rate_doubler_tb_top.sv
module line_rate_doubler_tb_top;

  localparam int L    = 5048;
  localparam int HALF = L / 2;
  localparam int AW   = $clog2(L);

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0, slowGrade = 1'b0;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [7:0]    wrLine, rdLine;
  logic          wrRst, rdRst, rdPass, rdValid, rdUndef;

  int checkCnt = 0;
  int failCnt  = 0;
  int wrTotal  = 0;

  line_rate_doubler dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .slowGrade(slowGrade),
    .wrAddr(wrAddr), .wrRst(wrRst), .wrLine(wrLine),
    .rdAddr(rdAddr), .rdRst(rdRst), .rdPass(rdPass), .rdValid(rdValid),
    .rdUndef(rdUndef), .rdLine(rdLine)
  );

  // 250 MHz read clock; write clock at half rate with aligned rising edges.
  always #2 begin
    rdClk = ~rdClk;
    if (rdClk) wrClk = ~wrClk;
  end

  // Count completed write cycles since reset release.
  always @(posedge wrClk) begin
    if (!rstN) wrTotal <= 0;
    else       wrTotal <= wrTotal + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit slow);
    rstN = 1'b0;
    slowGrade = slow;
    repeat (4) @(negedge rdClk);
    @(negedge wrClk);
    @(negedge rdClk);
    rstN = 1'b1;
  endtask

  // R1: outputs directly after reset release
  task automatic test_reset_state(input bit slow);
    apply_reset(slow);
    chk(wrAddr == '0, "R1", "wrAddr", int'(wrAddr), 0);
    chk(wrRst == 1'b1, "R1", "wrRst", int'(wrRst), 1);
    chk(wrLine == '0, "R1", "wrLine", int'(wrLine), 0);
    chk(rdValid == 1'b0, "R1", "rdValid", int'(rdValid), 0);
    chk(rdRst == 1'b0, "R1", "rdRst", int'(rdRst), 0);
    chk(rdUndef == 1'b0, "R1", "rdUndef", int'(rdUndef), 0);
    chk(rdPass == 1'b0, "R1", "rdPass", int'(rdPass), 0);
  endtask

  // Continuous run: monitors every read cycle and checks R2..R9.
  task automatic run_lines(input int nSamples, input bit slow);
    bit  prevValid = 1'b0;
    bit  prevPass  = 1'b0;
    int  prevAddr  = 0;
    int  prevLine  = 0;
    int  benchLine = 0;
    int  undefSeen = 0;
    int  nUndef    = slow ? 15 : 21;
    int  firstStarts = 0;
    int  secondStarts = 0;
    for (int s = 0; s < nSamples; s++) begin
      @(negedge rdClk);
      // R2: write side against the bench's own write count
      chk(int'(wrAddr) == wrTotal % L, "R2", "wrAddr", int'(wrAddr), wrTotal % L);
      chk(wrRst == (wrAddr == '0), "R2", "wrRst", int'(wrRst), int'(wrAddr == '0));
      chk(int'(wrLine) == (wrTotal / L) % 256, "R2", "wrLine", int'(wrLine), (wrTotal / L) % 256);
      if (!rdValid) begin
        chk(!rdRst && !rdUndef, "R6", "idle strobes", int'({rdRst, rdUndef}), 0);
        chk(!prevValid, "R8", "read valid dropped", 0, 1);
      end else if (rdRst && !rdPass) begin
        // R3: first pass starts half a write cycle after the mid-line point
        firstStarts++;
        chk(rdAddr == '0, "R3", "first pass addr", int'(rdAddr), 0);
        chk(int'(wrAddr) == HALF, "R3", "wrAddr at first pass", int'(wrAddr), HALF);
        chk(rdLine == wrLine, "R3", "rdLine", int'(rdLine), int'(wrLine));
        if (prevValid)
          chk(prevPass && prevAddr == L - 1, "R8", "previous addr before new line",
              prevAddr, L - 1);
        benchLine = wrTotal / L;
        undefSeen = 0;
      end else if (rdRst && rdPass) begin
        // R5: second pass follows the first immediately
        secondStarts++;
        chk(prevValid && !prevPass && prevAddr == L - 1, "R5", "addr before second pass",
            prevAddr, L - 1);
        chk(rdAddr == '0, "R5", "second pass addr", int'(rdAddr), 0);
        chk(int'(rdLine) == prevLine, "R5", "rdLine kept", int'(rdLine), prevLine);
        // R7: count of flagged outputs in the completed first pass
        chk(undefSeen == nUndef, "R7", "flagged outputs per first pass", undefSeen, nUndef);
      end else begin
        // R4: increment within a pass
        chk(prevValid && rdPass == prevPass && int'(rdAddr) == prevAddr + 1, "R4",
            "read addr step", int'(rdAddr), prevAddr + 1);
      end
      if (rdValid) begin
        bit expUndef = !rdPass && (int'(rdAddr) >= L - nUndef);
        chk(rdUndef == expUndef, "R6", "undefined flag", int'(rdUndef), int'(expUndef));
        if (rdUndef) undefSeen++;
        if (!expUndef) begin
          int lo = benchLine * L + int'(rdAddr);
          // R9: byte is current for this line (written, not yet overwritten)
          chk(wrTotal > lo && wrTotal <= lo + L, "R9", "byte freshness (write count)",
              wrTotal, lo + 1);
        end
      end
      prevValid = rdValid;
      prevPass  = rdPass;
      prevAddr  = int'(rdAddr);
      prevLine  = int'(rdLine);
    end
    chk(firstStarts >= 2, "R3", "first passes seen", firstStarts, 2);
    chk(secondStarts >= 2, "R5", "second passes seen", secondStarts, 2);
  endtask

  // R1: reset in the middle of a line returns everything to the reset state
  task automatic test_midline_reset();
    apply_reset(1'b0);
    repeat (7000) @(negedge rdClk);
    chk(rdValid == 1'b1, "R3", "reading before mid reset", int'(rdValid), 1);
    test_reset_state(1'b0);
  endtask

  initial begin
    #700000;
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    test_reset_state(1'b0);
    run_lines(27000, 1'b0);
    test_reset_state(1'b1);
    run_lines(27000, 1'b1);
    test_midline_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule